// File: doc/BRIEF.md
# Programmable Duty PWM Generator with Full-On and Shutdown

This block produces one pulse-width modulated output whose period is split into 32 equal steps. A 5-bit duty code selects how many of those steps, counted from the start of the period, drive the output high. Code 0 holds the output low. Code 31 gives 31/32 of the period high. A separate full-on request holds the output high for the whole period, so the usable range extends to 100%. A shutdown request releases the output: the output enable drops, the level is forced low and all counters stop.

The system clock is divided by `CLK_HZ / (FREQ_HZ * 32)` to produce one step tick. Both values are build-time parameters, and elaboration rejects any ratio that is not a whole number of at least 1. The duty code and the full-on request are sampled only when the step counter wraps from its last step back to step 0, so a period is never cut short or stretched. A new setting therefore reaches the output within two periods.

Out of reset the generator runs on its own at the mid-scale code (50% duty) with the output enabled. It is controlled by a register slave that supplies the code, the full-on request and the shutdown request. When shutdown is released, the generator restarts at step 0 with the setting it held before, so the first period after release is complete.

Top module: `duty_pwm_gen`

## Requirements
- R1: After reset the output enable is 1 and the held setting is code 10000b with full-on clear, so the output is high for exactly 16 of every 32 steps, starting at the first cycle after reset.
- R2: One period lasts 32 × DIV clock cycles, where DIV = CLK_HZ / (FREQ_HZ × 32). With code C (full-on clear), the output is high for exactly C × DIV cycles in every period and has at most one rising edge in any one-period window.
- R3: With code 00000b and full-on clear, the output stays low for the whole period.
- R4: With full-on set, the output stays high for the whole period whatever the duty code, including code 00000b.
- R5: From the cycle after shutdown is sampled high, the output enable is 0, the output level is 0, and both stay so while shutdown is held.
- R6: In the cycle after shutdown is sampled low, the output enable returns to 1 and a complete period begins at step 0 with the setting held before shutdown. Step s of that period (0-based) is high when s is less than the held code.
- R7: The code and full-on inputs are taken only at a period boundary. A change made partway through a period leaves the rest of that period following the old setting.
- R8: A new code or full-on value appears at the output within two periods of being applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_code | input | CODE_W | Requested number of high steps per period |
| full_on | input | 1 | Request 100% duty, overriding duty_code |
| shutdown | input | 1 | Release the output and stop the counters |
| pwm_level | output | 1 | PWM output level, 0 whenever the output is disabled |
| pwm_oe | output | 1 | Output enable; 0 means the pin is high-impedance |

## Verification
The bench sweeps every code, plus full-on with code 0. For each setting it counts high cycles and rising edges over a window of exactly one period. A design that compares with `<=` or miscounts the prescaler would show a count off by DIV. A design that let code 0 leak a step high, or let full-on dip low at the wrap, would fail the zero and full-on checks. The sharpest cases are the restart after shutdown and a code change made ten cycles into that restarted period. A design that restarted mid-step would shorten the first high pulse. A design that latched settings immediately would switch the remainder of the period to the new code. Both show up in a cycle-by-cycle comparison against an arithmetically aligned expectation.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

   // Output drive mode chosen from the held setting and the run state
   typedef enum logic [1:0] {
      DRV_OFF  = 2'd0,
      DRV_DUTY = 2'd1,
      DRV_FULL = 2'd2
   } drive_mode_e;

   function automatic int unsigned step_divider(input longint unsigned clk_hz,
                                                input longint unsigned freq_hz,
                                                input int unsigned     steps);
      return int'(clk_hz / (freq_hz * steps));
   endfunction

endpackage

// File: rtl/pwm_step_tick.sv
module pwm_step_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_pass
         assign tick = en & ~clr;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (en) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end

         assign tick = en & ~clr & (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pwm_period_seq.sv
module pwm_period_seq #(
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              shutdown,
   input  logic [CODE_W-1:0] duty_code,
   input  logic              full_on,
   output logic              run_q,
   output logic [CODE_W-1:0] step_q,
   output logic [CODE_W-1:0] held_code,
   output logic              held_full
);
   localparam logic [CODE_W-1:0] LAST_STEP  = '1;
   localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(1) << (CODE_W - 1);

   logic wrap;
   assign wrap = tick & (step_q == LAST_STEP) & ~shutdown;

   // run_q is 1 while the output is driven; counting begins one cycle after release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
      end else begin
         run_q <= ~shutdown;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (shutdown) begin
         step_q <= '0;
      end else if (tick) begin
         step_q <= step_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_code <= RESET_CODE;
         held_full <= 1'b0;
      end else if (wrap) begin
         held_code <= duty_code;
         held_full <= full_on;
      end
   end
endmodule

// File: rtl/pwm_drive_stage.sv
module pwm_drive_stage
   import pwm_gen_pkg::*;
#(
   parameter int unsigned CODE_W = 5
) (
   input  logic              run_q,
   input  logic [CODE_W-1:0] step_q,
   input  logic [CODE_W-1:0] held_code,
   input  logic              held_full,
   output logic              level,
   output logic              oe
);
   drive_mode_e mode;

   always_comb begin
      if (!run_q)         mode = DRV_OFF;
      else if (held_full) mode = DRV_FULL;
      else                mode = DRV_DUTY;
   end

   always_comb begin
      unique case (mode)
         DRV_FULL: level = 1'b1;
         DRV_DUTY: level = (step_q < held_code);
         default:  level = 1'b0;
      endcase
   end

   assign oe = (mode != DRV_OFF);
endmodule

// File: rtl/duty_pwm_gen.sv
module duty_pwm_gen
   import pwm_gen_pkg::*;
#(
   parameter longint unsigned CLK_HZ  = 32_000_000,
   parameter longint unsigned FREQ_HZ = 25_000,
   parameter int unsigned     CODE_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] duty_code,
   input  logic              full_on,
   input  logic              shutdown,
   output logic              pwm_level,
   output logic              pwm_oe
);
   localparam int unsigned STEPS = 1 << CODE_W;
   localparam int unsigned DIV   = step_divider(CLK_HZ, FREQ_HZ, STEPS);

   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("duty_pwm_gen: CODE_W must be at least 2");
      end
      if (DIV < 1) begin : g_bad_ratio
         $error("duty_pwm_gen: clock too slow for the requested output frequency");
      end
      if (longint'(DIV) * FREQ_HZ * STEPS != CLK_HZ) begin : g_bad_div
         $error("duty_pwm_gen: clock is not a whole multiple of the step rate");
      end
   endgenerate

   logic              tick;
   logic              run_q;
   logic [CODE_W-1:0] step_q;
   logic [CODE_W-1:0] held_code;
   logic              held_full;

   pwm_step_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (shutdown),
      .en   (run_q),
      .tick (tick)
   );

   pwm_period_seq #(.CODE_W(CODE_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .shutdown (shutdown),
      .duty_code(duty_code),
      .full_on  (full_on),
      .run_q    (run_q),
      .step_q   (step_q),
      .held_code(held_code),
      .held_full(held_full)
   );

   pwm_drive_stage #(.CODE_W(CODE_W)) u_drive (
      .run_q    (run_q),
      .step_q   (step_q),
      .held_code(held_code),
      .held_full(held_full),
      .level    (pwm_level),
      .oe       (pwm_oe)
   );
endmodule

// File: rtl/duty_pwm_gen_chk.sv
module duty_pwm_gen_chk #(
   parameter int unsigned CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shutdown,
   input logic              pwm_level,
   input logic              pwm_oe,
   input logic [CODE_W-1:0] step_q,
   input logic [CODE_W-1:0] held_code,
   input logic              held_full
);
   AST_SHUTDOWN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> !pwm_oe) else $error("shutdown did not release output"); // R5

   AST_LOW_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe |-> !pwm_level) else $error("level high while released"); // R5

   AST_FULL_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_oe && held_full) |-> pwm_level) else $error("full-on dropped low"); // R4

   AST_ZERO_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_oe && !held_full && held_code == '0) |-> !pwm_level) else $error("code zero high"); // R3

   AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != '0) |-> ($stable(held_code) && $stable(held_full))) else $error("setting changed mid-period"); // R7

   AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_oe) |-> (step_q == '0)) else $error("restart not at step 0"); // R6
endmodule

bind duty_pwm_gen duty_pwm_gen_chk #(.CODE_W(CODE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .shutdown (shutdown),
   .pwm_level(pwm_level),
   .pwm_oe   (pwm_oe),
   .step_q   (step_q),
   .held_code(held_code),
   .held_full(held_full)
);

// File: tb/tb_duty_pwm_gen.sv
`timescale 1ns/1ps
module tb_duty_pwm_gen;
   localparam int unsigned     CODE_W  = 5;
   localparam int unsigned     STEPS   = 32;
   localparam int unsigned     DIV     = 3;
   localparam longint unsigned FREQ_HZ = 1_000;
   localparam longint unsigned CLK_HZ  = FREQ_HZ * STEPS * DIV;
   localparam int unsigned     P       = STEPS * DIV;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CODE_W-1:0] duty_code = '0;
   logic              full_on = 1'b0;
   logic              shutdown = 1'b0;
   logic              pwm_level;
   logic              pwm_oe;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   duty_pwm_gen #(.CLK_HZ(CLK_HZ), .FREQ_HZ(FREQ_HZ), .CODE_W(CODE_W)) dut (
      .clk(clk), .rst_n(rst_n), .duty_code(duty_code), .full_on(full_on),
      .shutdown(shutdown), .pwm_level(pwm_level), .pwm_oe(pwm_oe)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   // Count high cycles and rising edges over one period; sampled at negedges
   task automatic measure(output int highs, output int rises, output int oe_low);
      logic prev;
      highs = 0; rises = 0; oe_low = 0;
      @(negedge clk);
      prev = pwm_level;
      for (int i = 0; i < P; i++) begin
         if (pwm_level) highs++;
         if (pwm_level && !prev && i > 0) rises++;
         if (!pwm_oe) oe_low++;
         prev = pwm_level;
         if (i < P - 1) @(negedge clk);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int h, r, o, mism;
      // R1: reset state
      wait_cycles(3);
      rst_n = 1'b1;
      duty_code = 5'd16;
      check("R1 oe after reset", int'(pwm_oe), 1);
      check("R1 first step high", int'(pwm_level), 1);
      measure(h, r, o);
      check("R1 mid-scale duty", h, 16 * DIV);

      // R2/R3/R8: sweep every code, measured two periods after the change
      for (int c = 0; c < STEPS; c++) begin
         duty_code = CODE_W'(c);
         wait_cycles(2 * P);
         measure(h, r, o);
         if (c == 0) check("R3 code zero low", h, 0);
         else        check("R2 R8 duty count", h, c * DIV);
         check("R2 single rising edge", int'(r <= 1), 1);
         check("R2 oe stays high", o, 0);
      end

      // R4: full-on overrides code zero and code 31
      duty_code = '0;
      full_on   = 1'b1;
      wait_cycles(2 * P);
      measure(h, r, o);
      check("R4 full-on with code 0", h, P);
      duty_code = 5'd31;
      wait_cycles(2 * P);
      measure(h, r, o);
      check("R4 full-on with code 31", h, P);
      full_on = 1'b0;
      duty_code = 5'd20;
      wait_cycles(2 * P);
      measure(h, r, o);
      check("R8 leave full-on", h, 20 * DIV);

      // R5: shutdown releases the output
      shutdown = 1'b1;
      @(negedge clk);
      check("R5 oe low next cycle", int'(pwm_oe), 0);
      check("R5 level low next cycle", int'(pwm_level), 0);
      mism = 0;
      for (int i = 0; i < P + 5; i++) begin
         @(negedge clk);
         if (pwm_oe || pwm_level) mism++;
      end
      check("R5 held released", mism, 0);

      // R6/R7: release, restarted period follows old code 20 although code 6 arrives at cycle 10
      shutdown = 1'b0;
      mism = 0;
      for (int j = 0; j < P; j++) begin
         @(negedge clk);
         if (!pwm_oe) mism++;
         if (int'(pwm_level) != int'((j / DIV) < 20)) mism++;
         if (j == 10) duty_code = 5'd6;
      end
      check("R6 R7 complete first period with held code", mism, 0);
      mism = 0;
      for (int j = 0; j < P; j++) begin
         @(negedge clk);
         if (int'(pwm_level) != int'((j / DIV) < 6)) mism++;
      end
      check("R7 R8 new code from next boundary", mism, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule